// File: doc/BRIEF.md
# Full-Circle Pipelined Vector Rotator

This block turns a two-component vector (I, Q) through an arbitrary angle anywhere on the circle, using shift-and-add micro-rotations only. The angle is a 16-bit unsigned binary fraction of a turn, so 0x4000 is a quarter turn and the code wraps naturally at 0x10000.

A front controller folds angles that lie between a quarter and three quarters of a turn. It does this by a half-turn pre-rotation, which negates both components and flips the top angle bit, so the residual angle always lies within plus or minus a quarter turn. A fully unrolled chain of micro-rotation stages then drives that residual towards zero. Each stage has one register and its own hardwired arctangent step.

A final stage multiplies both components by a fixed-point reciprocal of the chain gain, with rounding. A new sample may enter on every clock. Each sample carries a tag and a valid flag that move in lock-step with it, so the consumer can match each result to its source sample.

Top module: `vec_rotator_pipe`

## Requirements
- R1: With θ = angle·360/65536 degrees (angle read as unsigned 16 bits), the result is (I·cosθ − Q·sinθ, I·sinθ + Q·cosθ). Each component is within 3 + 0.0004·√(I²+Q²) LSB of that value.
- R2: R1 holds in all four quadrants, including the codes 0x0000, 0x3FFF, 0x4000, 0x4001, 0x8000, 0xBFFF, 0xC000, 0xC001 and 0xFFFF.
- R3: The chain gain is removed: inputs with components at the extremes (−32768 and 32767) give results within the R1 tolerance, with no overflow of the 17-bit signed outputs.
- R4: A sample taken at a rising edge with start high is presented with out_valid high after the 18th rising edge, counting the capturing edge as the first (latency = stages + 2).
- R5: Samples started on consecutive clocks come out on consecutive clocks, in the same order.
- R6: out_tag equals the in_tag that was captured with the sample now being presented.
- R7: busy is high exactly when at least one captured sample has not yet left the output register (including the cycle in which out_valid is high).
- R8: A synchronous active-high reset discards every sample in flight: out_valid and busy are low during reset and after it, until new samples arrive.
- R9: A clock edge with start low captures nothing: whatever is on the data inputs, no result appears for that edge.
- R10: A zero vector gives exactly zero on both outputs for any angle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture the input sample at this edge |
| in_i | input | 16 | First vector component, signed |
| in_q | input | 16 | Second vector component, signed |
| in_angle | input | 16 | Rotation angle, unsigned fraction of a full turn |
| in_tag | input | 8 | Position tag carried with the sample |
| busy | output | 1 | A captured sample is still in the pipeline |
| out_valid | output | 1 | out_i, out_q and out_tag hold a result |
| out_i | output | 17 | Rotated first component, signed |
| out_q | output | 17 | Rotated second component, signed |
| out_tag | output | 8 | Tag of the presented result |

## Verification
The angle set walks every quadrant edge, where the fold decision changes. A missing or misplaced negation therefore shows up as a sign error in one quadrant only, while the others still match. Vectors at the extremes of the input range separate a correct gain scale and guard width from an overflow or a wrong constant. A zero vector separates true arithmetic from a rounding offset, and a long back-to-back random stream with distinct tags shows whether data, valid and tag stay aligned at full throughput. A reset in the middle of a burst, and idle cycles with noisy inputs, show that nothing leaks out when no sample was taken.

// File: rtl/rot_pkg.sv
package rot_pkg;
   // Arctangent of 2^-idx in units of 1/65536 of a full turn.
   function automatic int atan_units(input int idx);
      case (idx)
         0:  return 8192;
         1:  return 4836;
         2:  return 2555;
         3:  return 1297;
         4:  return 651;
         5:  return 326;
         6:  return 163;
         7:  return 81;
         8:  return 41;
         9:  return 20;
         10: return 10;
         11: return 5;
         12: return 3;
         13: return 1;
         14: return 1;
         default: return 0;
      endcase
   endfunction

   localparam int TABLE_ANGLE_W = 16;
   localparam int MAX_STAGES    = 16;
endpackage

// File: rtl/rot_quadrant_fold.sv
module rot_quadrant_fold #(
   parameter int DATA_W  = 16,
   parameter int ANGLE_W = 16,
   parameter int TAG_W   = 8,
   parameter int GUARD   = 4,
   parameter int IW      = DATA_W + 2 + GUARD
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      v_i,
   input  logic signed [DATA_W-1:0]  x_i,
   input  logic signed [DATA_W-1:0]  y_i,
   input  logic        [ANGLE_W-1:0] ang_i,
   input  logic        [TAG_W-1:0]   tag_i,
   output logic                      v_o,
   output logic signed [IW-1:0]      x_o,
   output logic signed [IW-1:0]      y_o,
   output logic signed [ANGLE_W-1:0] z_o,
   output logic        [TAG_W-1:0]   tag_o
);
   localparam int EXT = IW - DATA_W - GUARD;

   logic                 flip;
   logic signed [IW-1:0] x_ext, y_ext;

   // Second and third quadrants: top two angle bits differ.
   assign flip  = ang_i[ANGLE_W-1] ^ ang_i[ANGLE_W-2];
   assign x_ext = {{EXT{x_i[DATA_W-1]}}, x_i, {GUARD{1'b0}}};
   assign y_ext = {{EXT{y_i[DATA_W-1]}}, y_i, {GUARD{1'b0}}};

   always_ff @(posedge clk) begin
      if (rst) v_o <= 1'b0;
      else     v_o <= v_i;
   end

   always_ff @(posedge clk) begin
      tag_o <= tag_i;
      if (flip) begin
         x_o <= -x_ext;
         y_o <= -y_ext;
         z_o <= {~ang_i[ANGLE_W-1], ang_i[ANGLE_W-2:0]};
      end else begin
         x_o <= x_ext;
         y_o <= y_ext;
         z_o <= ang_i;
      end
   end
endmodule

// File: rtl/rot_micro_stage.sv
module rot_micro_stage #(
   parameter int IW      = 22,
   parameter int ANGLE_W = 16,
   parameter int TAG_W   = 8,
   parameter int IDX     = 0
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      v_i,
   input  logic signed [IW-1:0]      x_i,
   input  logic signed [IW-1:0]      y_i,
   input  logic signed [ANGLE_W-1:0] z_i,
   input  logic        [TAG_W-1:0]   tag_i,
   output logic                      v_o,
   output logic signed [IW-1:0]      x_o,
   output logic signed [IW-1:0]      y_o,
   output logic signed [ANGLE_W-1:0] z_o,
   output logic        [TAG_W-1:0]   tag_o
);
   localparam int SCALE = ANGLE_W - rot_pkg::TABLE_ANGLE_W;
   localparam logic signed [ANGLE_W-1:0] STEP_ANG =
      ANGLE_W'(rot_pkg::atan_units(IDX)) <<< SCALE;

   logic signed [IW-1:0] xs, ys;
   logic                 ccw;

   assign xs  = x_i >>> IDX;
   assign ys  = y_i >>> IDX;
   assign ccw = ~z_i[ANGLE_W-1];

   always_ff @(posedge clk) begin
      if (rst) v_o <= 1'b0;
      else     v_o <= v_i;
   end

   always_ff @(posedge clk) begin
      tag_o <= tag_i;
      if (ccw) begin
         x_o <= x_i - ys;
         y_o <= y_i + xs;
         z_o <= z_i - STEP_ANG;
      end else begin
         x_o <= x_i + ys;
         y_o <= y_i - xs;
         z_o <= z_i + STEP_ANG;
      end
   end
endmodule

// File: rtl/rot_gain_scale.sv
module rot_gain_scale #(
   parameter int IW        = 22,
   parameter int OUT_W     = 17,
   parameter int TAG_W     = 8,
   parameter int GUARD     = 4,
   parameter int GAIN_FRAC = 16,
   parameter int GAIN_Q    = 39797
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    v_i,
   input  logic signed [IW-1:0]    x_i,
   input  logic signed [IW-1:0]    y_i,
   input  logic        [TAG_W-1:0] tag_i,
   output logic                    v_o,
   output logic signed [OUT_W-1:0] x_o,
   output logic signed [OUT_W-1:0] y_o,
   output logic        [TAG_W-1:0] tag_o
);
   localparam int PW = IW + GAIN_FRAC + 2;
   localparam int SH = GAIN_FRAC + GUARD;
   localparam logic signed [PW-1:0] GQ   = PW'(GAIN_Q);
   localparam logic signed [PW-1:0] HALF = PW'(1) <<< (SH - 1);

   logic signed [PW-1:0] px, py, rx, ry;

   assign px = PW'(x_i) * GQ;
   assign py = PW'(y_i) * GQ;
   assign rx = (px + HALF) >>> SH;
   assign ry = (py + HALF) >>> SH;

   always_ff @(posedge clk) begin
      if (rst) v_o <= 1'b0;
      else     v_o <= v_i;
   end

   always_ff @(posedge clk) begin
      tag_o <= tag_i;
      x_o   <= OUT_W'(rx);
      y_o   <= OUT_W'(ry);
   end
endmodule

// File: rtl/vec_rotator_pipe.sv
module vec_rotator_pipe #(
   parameter int DATA_W    = 16,
   parameter int ANGLE_W   = 16,
   parameter int TAG_W     = 8,
   parameter int STAGES    = 16,
   parameter int GUARD     = 4,
   parameter int GAIN_FRAC = 16,
   parameter int GAIN_Q    = 39797
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    start,
   input  logic signed [DATA_W-1:0] in_i,
   input  logic signed [DATA_W-1:0] in_q,
   input  logic [ANGLE_W-1:0]      in_angle,
   input  logic [TAG_W-1:0]        in_tag,
   output logic                    busy,
   output logic                    out_valid,
   output logic signed [DATA_W:0]  out_i,
   output logic signed [DATA_W:0]  out_q,
   output logic [TAG_W-1:0]        out_tag
);
   localparam int IW    = DATA_W + 2 + GUARD;
   localparam int OUT_W = DATA_W + 1;

   generate
      if (STAGES < 4 || STAGES > rot_pkg::MAX_STAGES)
         $error("STAGES must lie between 4 and 16");
      if (ANGLE_W < rot_pkg::TABLE_ANGLE_W || ANGLE_W > 24)
         $error("ANGLE_W must lie between 16 and 24");
      if (DATA_W < 4)
         $error("DATA_W must be at least 4");
      if (GUARD < 1)
         $error("GUARD must be at least 1");
      if (GAIN_Q <= 0 || GAIN_Q >= (1 << GAIN_FRAC))
         $error("GAIN_Q must be a positive fraction");
   endgenerate

   logic        [STAGES:0]     sv;
   logic signed [IW-1:0]       sx   [STAGES+1];
   logic signed [IW-1:0]       sy   [STAGES+1];
   logic signed [ANGLE_W-1:0]  sz   [STAGES+1];
   logic        [TAG_W-1:0]    stag [STAGES+1];

   rot_quadrant_fold #(
      .DATA_W(DATA_W), .ANGLE_W(ANGLE_W), .TAG_W(TAG_W),
      .GUARD(GUARD), .IW(IW)
   ) u_fold (
      .clk(clk), .rst(rst),
      .v_i(start), .x_i(in_i), .y_i(in_q), .ang_i(in_angle), .tag_i(in_tag),
      .v_o(sv[0]), .x_o(sx[0]), .y_o(sy[0]), .z_o(sz[0]), .tag_o(stag[0])
   );

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      rot_micro_stage #(
         .IW(IW), .ANGLE_W(ANGLE_W), .TAG_W(TAG_W), .IDX(k)
      ) u_stage (
         .clk(clk), .rst(rst),
         .v_i(sv[k]), .x_i(sx[k]), .y_i(sy[k]), .z_i(sz[k]), .tag_i(stag[k]),
         .v_o(sv[k+1]), .x_o(sx[k+1]), .y_o(sy[k+1]), .z_o(sz[k+1]),
         .tag_o(stag[k+1])
      );
   end

   rot_gain_scale #(
      .IW(IW), .OUT_W(OUT_W), .TAG_W(TAG_W), .GUARD(GUARD),
      .GAIN_FRAC(GAIN_FRAC), .GAIN_Q(GAIN_Q)
   ) u_gain (
      .clk(clk), .rst(rst),
      .v_i(sv[STAGES]), .x_i(sx[STAGES]), .y_i(sy[STAGES]), .tag_i(stag[STAGES]),
      .v_o(out_valid), .x_o(out_i), .y_o(out_q), .tag_o(out_tag)
   );

   // The residual angle of the last stage is not needed past the chain.
   logic unused_z;
   assign unused_z = ^sz[STAGES];

   always_comb begin
      busy = out_valid | (|sv) | (unused_z & 1'b0);
   end
endmodule

// File: rtl/vec_rotator_chk.sv
module vec_rotator_chk #(
   parameter int STAGES = 16,
   parameter int TAG_W  = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             start,
   input logic [TAG_W-1:0] in_tag,
   input logic             busy,
   input logic             out_valid,
   input logic [TAG_W-1:0] out_tag
);
   localparam int LAT = STAGES + 2;

   logic [LAT-1:0]   trk;
   logic [TAG_W-1:0] ttrk [LAT];

   always_ff @(posedge clk) begin
      if (rst) trk <= '0;
      else     trk <= {trk[LAT-2:0], start};
   end

   always_ff @(posedge clk) begin
      ttrk[0] <= in_tag;
      for (int k = 1; k < LAT; k++) ttrk[k] <= ttrk[k-1];
   end

   // R4: result appears exactly LAT edges after capture
   p_latency_r4: assert property (@(posedge clk) disable iff (rst)
      out_valid == trk[LAT-1]);

   // R6: tag presented with a result is the tag captured with it
   p_tag_match_r6: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_tag == ttrk[LAT-1]));

   // R7: busy tracks samples still in flight
   p_busy_inflight_r7: assert property (@(posedge clk) disable iff (rst)
      busy == (|trk));

   // R8: leaving reset, nothing is in flight
   p_reset_idle_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!busy && !out_valid));
endmodule

bind vec_rotator_pipe vec_rotator_chk #(.STAGES(STAGES), .TAG_W(TAG_W)) u_chk (
   .clk(clk), .rst(rst), .start(start), .in_tag(in_tag),
   .busy(busy), .out_valid(out_valid), .out_tag(out_tag)
);

// File: tb/vec_rotator_pipe_bench.sv
module vec_rotator_pipe_bench;
   localparam int LAT = 18;   // R4: stages + 2

   logic clk = 1'b0;
   always #4 clk = ~clk;      // 125 MHz

   logic               rst = 1'b1;
   logic               start = 1'b0;
   logic signed [15:0] in_i = '0, in_q = '0;
   logic        [15:0] in_angle = '0;
   logic        [7:0]  in_tag = '0;
   logic               busy, out_valid;
   logic signed [16:0] out_i, out_q;
   logic        [7:0]  out_tag;

   vec_rotator_pipe u_vec_rotator_pipe (
      .clk(clk), .rst(rst), .start(start), .in_i(in_i), .in_q(in_q),
      .in_angle(in_angle), .in_tag(in_tag), .busy(busy),
      .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .out_tag(out_tag)
   );

   typedef struct {
      real    ex;
      real    ey;
      real    tol;
      bit     zero;
      int     tag;
      longint due;
      string  req;
   } exp_t;

   exp_t   q[$];
   int     n_checks = 0, n_fail = 0;
   longint ecount = 0;

   always @(posedge clk) ecount <= ecount + 1;

   function automatic real rabs(input real v);
      return (v < 0.0) ? -v : v;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input real act, input real exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0f expected %0f", req, what, act, exp);
      end
   endtask

   task automatic observe();
      bit   exp_v, exp_b;
      exp_t e;
      if (rst) begin
         chk(out_valid == 1'b0, "R8", "out_valid in reset", real'(out_valid), 0.0);
         chk(busy == 1'b0, "R8", "busy in reset", real'(busy), 0.0);
         q.delete();
         return;
      end
      exp_b = (q.size() > 0);
      exp_v = exp_b && (q[0].due == ecount);
      chk(out_valid == exp_v, exp_b ? "R4" : "R9", "out_valid",
          real'(out_valid), real'(exp_v));
      chk(busy == exp_b, "R7", "busy", real'(busy), real'(exp_b));
      if (exp_v) begin
         e = q.pop_front();
         if (out_valid) begin
            chk(int'(out_tag) == e.tag, "R6", "out_tag", real'(out_tag), real'(e.tag));
            if (e.zero) begin
               chk(out_i == 0, "R10", "out_i", real'(out_i), 0.0);
               chk(out_q == 0, "R10", "out_q", real'(out_q), 0.0);
            end else begin
               chk(rabs(real'(out_i) - e.ex) <= e.tol, e.req, "out_i", real'(out_i), e.ex);
               chk(rabs(real'(out_q) - e.ey) <= e.tol, e.req, "out_q", real'(out_q), e.ey);
            end
         end
      end
   endtask

   task automatic step(input bit st, input int xi, input int yi, input int ang,
                       input int tg, input string req);
      exp_t e;
      real  th, mag;
      @(negedge clk);
      observe();
      start    = st;
      in_i     = 16'(xi);
      in_q     = 16'(yi);
      in_angle = 16'(ang);
      in_tag   = 8'(tg);
      if (st && !rst) begin
         th     = real'(ang & 16'hFFFF) * 2.0 * 3.14159265358979 / 65536.0;
         mag    = $sqrt(real'(xi) * real'(xi) + real'(yi) * real'(yi));
         e.ex   = real'(xi) * $cos(th) - real'(yi) * $sin(th);
         e.ey   = real'(xi) * $sin(th) + real'(yi) * $cos(th);
         e.tol  = 3.0 + 0.0004 * mag;
         e.zero = (xi == 0) && (yi == 0);
         e.tag  = tg & 8'hFF;
         e.due  = ecount + LAT;
         e.req  = req;
         q.push_back(e);
      end
   endtask

   task automatic reset_for(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         observe();
         rst   = 1'b1;
         start = 1'b0;
      end
      @(negedge clk);
      observe();
      rst = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++)
         step(1'b0, int'($urandom & 16'hFFFF) - 32768, int'($urandom & 16'hFFFF) - 32768,
              int'($urandom & 16'hFFFF), int'($urandom & 8'hFF), "R9");
   endtask

   always @(posedge clk) begin
      if (ecount > 60000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected below 60000", ecount);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int angs[11];
      angs = '{16'h0000, 16'h3FFF, 16'h4000, 16'h4001, 16'h8000, 16'hBFFF,
               16'hC000, 16'hC001, 16'hFFFF, 16'h7000, 16'h9000};

      // R8: reset state
      reset_for(3);

      // R9: start low with noisy inputs
      idle(6);

      // R1: single samples, pipeline drained in between
      step(1'b1, 10000, 5000, 16'h1000, 1, "R1");
      idle(LAT + 2);
      step(1'b1, -12000, 7000, 16'h2AAA, 2, "R1");
      idle(LAT + 2);

      // R2 and R5: quadrant edges, back to back
      for (int k = 0; k < 11; k++)
         step(1'b1, 15000, -9000, angs[k], 16 + k, "R2");
      for (int k = 0; k < 11; k++)
         step(1'b1, -20000, -3000, angs[k], 32 + k, "R2");
      idle(LAT + 2);

      // R3: extreme components
      step(1'b1, -32768, -32768, 16'h2000, 60, "R3");
      step(1'b1, 32767, 32767, 16'hE000, 61, "R3");
      step(1'b1, 32767, -32768, 16'h6000, 62, "R3");
      step(1'b1, -32768, 32767, 16'hA000, 63, "R3");
      step(1'b1, -32768, 0, 16'h8000, 64, "R3");
      idle(LAT + 2);

      // R10: zero vector
      step(1'b1, 0, 0, 16'h1234, 70, "R10");
      step(1'b1, 0, 0, 16'hC987, 71, "R10");
      idle(LAT + 2);

      // R5 and R6: long random stream at full rate
      for (int k = 0; k < 300; k++)
         step(1'b1, int'($urandom % 60001) - 30000, int'($urandom % 60001) - 30000,
              int'($urandom & 16'hFFFF), k & 8'hFF, "R5");
      idle(LAT + 2);

      // R8: reset in the middle of a burst discards everything in flight
      for (int k = 0; k < 10; k++)
         step(1'b1, 5000 + k, 3000, 16'h0800 * k, 200 + k, "R8");
      reset_for(2);
      idle(LAT + 4);

      // R7: gaps in the stream keep busy aligned with samples in flight
      for (int k = 0; k < 40; k++)
         step(k % 3 == 0, 8000, -8000, 16'h0400 * k, 100 + k, "R7");
      idle(LAT + 4);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule